// File: doc/BRIEF.md
# Frame-Aligned TDM Slave Receiver

This block receives a time-division-multiplexed audio stream as the bit-clock slave. An external master drives the bit clock, the frame sync and the serial data. All three lines are oversampled by a faster system clock. The block gathers each slot into a 32-bit word, most significant bit first. It holds the words of a frame in a staging store and passes them downstream only once the whole frame has arrived. The output is a valid/ready word stream that carries a channel index and an end-of-frame marker.

The block never releases a partial frame. A frame is abandoned when a sync pulse arrives early or when the bit clock stops for longer than a programmable number of system clocks. The receiver then waits for the next sync pulse. Because of this, a sender that halts mid-frame and restarts cannot move samples into a different channel position. The first word of every delivered frame always belongs to channel 1.

A completed frame moves into a one-frame output store. If a new frame completes while that store is still occupied, the new frame is dropped as a unit and a sticky overflow flag is raised.

Top module: `tdm_frame_rx`

## Requirements
- R1: The sync pulse is sampled high on one rising bit-clock edge. The serial bit on the next rising edge is the MSB of slot 0, and each slot takes 32 consecutive bits MSB first, so out_data[31] is the first bit received in the slot.
- R2: A delivered frame is 16 words in slot order. out_chan equals the slot position (0 to 15), and word 0 always holds the slot that directly follows the sync pulse.
- R3: out_last is 1 on the word with out_chan = 15 and 0 on every other word.
- R4: No word of a frame is offered before the rising edge that carries the frame's 512th bit, and words appear only in groups of 16.
- R5: If a sync pulse arrives before 512 bits of the current frame are counted, the partial frame is discarded. The frame that this sync pulse starts is received normally.
- R6: If no rising bit-clock edge arrives for idle_limit system clocks during a frame, that frame is discarded. Later bits are ignored until the next sync pulse.
- R7: After reset, serial data and bit-clock edges that arrive before the first sync pulse produce no output.
- R8: While out_valid is 1 and out_ready is 0, out_data, out_chan and out_last stay unchanged. A word is consumed on a cycle where both are 1.
- R9: When a frame completes while the output store still holds undelivered words, the new frame is dropped entirely and overflow goes to 1. overflow stays at 1 until reset.
- R10: During reset, and right after it, out_valid is 0 and overflow is 0.
- R11: If a frame reaches its 512th bit without a sync pulse on that edge, the frame is still delivered. The receiver then waits for a sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Bit clock from the master (asynchronous) |
| ws_in | input | 1 | Frame sync pulse, one bit clock wide (asynchronous) |
| sd_in | input | 1 | Serial data (asynchronous) |
| idle_limit | input | TO_W | Bit-clock silence limit, in system clocks |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | SLOT_BITS | Slot word |
| out_chan | output | log2(SLOTS) | Slot position within the frame |
| out_last | output | 1 | Final word of the frame |
| overflow | output | 1 | Sticky: a completed frame was dropped |

## Verification
The bench uses the default geometry of 16 slots of 32 bits, two synchroniser stages, a bit clock of six system clocks and an idle_limit of 20. With these values the timeout can be reached by stalling the bit clock for 40 cycles, while normal running never comes close to it. Each frame takes about 3,000 cycles, so the run can cover back-to-back frames, an early sync, a stall followed by stray bits, and a stall of out_ready that overlaps a second frame, all within the cycle budget. Each frame uses distinct slot patterns, so a channel shift or a bit slip shows up as a data mismatch on the very next word.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
   // One sample of the three serial lines as seen in the system clock domain.
   typedef struct packed {
      logic sck;
      logic ws;
      logic sd;
   } tdm_pins_t;

   localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync
   import tdm_rx_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst,
   input  tdm_pins_t pins_in,
   output logic      ws_s,
   output logic      sd_s,
   output logic      sck_rise
);
   tdm_pins_t chain_q [STAGES];
   logic      sck_prev_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain_q[0] <= '0;
               else     chain_q[0] <= pins_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain_q[i] <= '0;
               else     chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) sck_prev_q <= 1'b0;
      else     sck_prev_q <= chain_q[STAGES-1].sck;
   end

   assign sck_rise = chain_q[STAGES-1].sck & ~sck_prev_q;
   assign ws_s     = chain_q[STAGES-1].ws;
   assign sd_s     = chain_q[STAGES-1].sd;
endmodule

// File: rtl/tdm_rx_deframer.sv
module tdm_rx_deframer #(
   parameter int SLOTS     = 16,
   parameter int SLOT_BITS = 32,
   parameter int TO_W      = 16,
   localparam int CH_W       = $clog2(SLOTS),
   localparam int BIT_W      = $clog2(SLOT_BITS),
   localparam int FRAME_BITS = SLOTS * SLOT_BITS,
   localparam int CNT_W      = CH_W + BIT_W
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  sck_rise,
   input  logic                  ws,
   input  logic                  sd,
   input  logic [TO_W-1:0]       idle_limit,
   output logic                  frame_done,
   output logic [SLOT_BITS-1:0]  frame_words [SLOTS]
);
   logic                 in_frame_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [SLOT_BITS-1:0] shreg_q;
   logic [TO_W-1:0]      idle_q;
   logic [SLOT_BITS-1:0] new_word;
   logic [CH_W-1:0]      slot_idx;
   logic                 slot_end;
   logic                 frame_end;

   assign new_word   = {shreg_q[SLOT_BITS-2:0], sd};
   assign slot_idx   = cnt_q[CNT_W-1:BIT_W];
   assign slot_end   = in_frame_q && (&cnt_q[BIT_W-1:0]);
   assign frame_end  = in_frame_q && (cnt_q == CNT_W'(FRAME_BITS - 1));
   assign frame_done = sck_rise && frame_end;

   // Bit counter, shift register, frame tracking and bit-clock watchdog.
   always_ff @(posedge clk) begin
      if (rst) begin
         in_frame_q <= 1'b0;
         cnt_q      <= '0;
         shreg_q    <= '0;
         idle_q     <= '0;
      end else if (sck_rise) begin
         idle_q <= '0;
         if (in_frame_q) begin
            shreg_q <= new_word;
            cnt_q   <= cnt_q + 1'b1;
         end
         if (ws) begin
            in_frame_q <= 1'b1;
            cnt_q      <= '0;
         end else if (frame_end) begin
            in_frame_q <= 1'b0;
         end
      end else begin
         if (idle_q != '1) idle_q <= idle_q + 1'b1;
         if (in_frame_q && (idle_q >= idle_limit)) in_frame_q <= 1'b0;
      end
   end

   // Staging store: every slot except the last, which is still in the
   // shift register on the completing edge.
   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         if (s < SLOTS - 1) begin : g_store
            logic [SLOT_BITS-1:0] word_q;
            always_ff @(posedge clk) begin
               if (rst)
                  word_q <= '0;
               else if (sck_rise && slot_end && (slot_idx == CH_W'(s)))
                  word_q <= new_word;
            end
            assign frame_words[s] = word_q;
         end else begin : g_tail
            assign frame_words[s] = new_word;
         end
      end
   endgenerate
endmodule

// File: rtl/tdm_rx_outbuf.sv
module tdm_rx_outbuf #(
   parameter int SLOTS     = 16,
   parameter int SLOT_BITS = 32,
   localparam int CH_W     = $clog2(SLOTS)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  frame_done,
   input  logic [SLOT_BITS-1:0]  frame_words [SLOTS],
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [SLOT_BITS-1:0]  out_data,
   output logic [CH_W-1:0]       out_chan,
   output logic                  out_last,
   output logic                  overflow
);
   logic [SLOT_BITS-1:0] hold_q [SLOTS];
   logic [CH_W-1:0]      idx_q;
   logic                 full_q;
   logic                 ovf_q;
   logic                 last_word;

   assign last_word = (idx_q == CH_W'(SLOTS - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
         idx_q  <= '0;
         ovf_q  <= 1'b0;
         for (int s = 0; s < SLOTS; s++) hold_q[s] <= '0;
      end else begin
         if (full_q && out_ready) begin
            if (last_word) begin
               full_q <= 1'b0;
               idx_q  <= '0;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
         if (frame_done) begin
            if (full_q) begin
               ovf_q <= 1'b1;
            end else begin
               full_q <= 1'b1;
               idx_q  <= '0;
               for (int s = 0; s < SLOTS; s++) hold_q[s] <= frame_words[s];
            end
         end
      end
   end

   assign out_valid = full_q;
   assign out_data  = hold_q[idx_q];
   assign out_chan  = idx_q;
   assign out_last  = full_q && last_word;
   assign overflow  = ovf_q;
endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx
   import tdm_rx_pkg::*;
#(
   parameter int SLOTS       = 16,
   parameter int SLOT_BITS   = 32,
   parameter int TO_W        = 16,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = $clog2(SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sck_in,
   input  logic                 ws_in,
   input  logic                 sd_in,
   input  logic [TO_W-1:0]      idle_limit,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [SLOT_BITS-1:0] out_data,
   output logic [CH_W-1:0]      out_chan,
   output logic                 out_last,
   output logic                 overflow
);
   generate
      if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
         $error("SLOTS must be a power of two, at least 2");
      end
      if (SLOT_BITS < 2 || (SLOT_BITS & (SLOT_BITS - 1)) != 0) begin : g_bad_bits
         $error("SLOT_BITS must be a power of two, at least 2");
      end
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
         $error("SYNC_STAGES below minimum");
      end
      if (TO_W < 2) begin : g_bad_to
         $error("TO_W must be at least 2");
      end
   endgenerate

   tdm_pins_t            pins;
   logic                 ws_s, sd_s, sck_rise;
   logic                 frame_done;
   logic [SLOT_BITS-1:0] frame_words [SLOTS];

   assign pins = '{sck: sck_in, ws: ws_in, sd: sd_in};

   tdm_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst      (rst),
      .pins_in  (pins),
      .ws_s     (ws_s),
      .sd_s     (sd_s),
      .sck_rise (sck_rise)
   );

   tdm_rx_deframer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS), .TO_W(TO_W)) i_deframer (
      .clk         (clk),
      .rst         (rst),
      .sck_rise    (sck_rise),
      .ws          (ws_s),
      .sd          (sd_s),
      .idle_limit  (idle_limit),
      .frame_done  (frame_done),
      .frame_words (frame_words)
   );

   tdm_rx_outbuf #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) i_outbuf (
      .clk         (clk),
      .rst         (rst),
      .frame_done  (frame_done),
      .frame_words (frame_words),
      .out_valid   (out_valid),
      .out_ready   (out_ready),
      .out_data    (out_data),
      .out_chan    (out_chan),
      .out_last    (out_last),
      .overflow    (overflow)
   );
endmodule

// File: rtl/tdm_rx_checker.sv
module tdm_rx_checker #(
   parameter int SLOTS     = 16,
   parameter int SLOT_BITS = 32,
   localparam int CH_W     = $clog2(SLOTS)
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 out_valid,
   input logic                 out_ready,
   input logic [SLOT_BITS-1:0] out_data,
   input logic [CH_W-1:0]      out_chan,
   input logic                 out_last,
   input logic                 overflow
);
   assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_data) && $stable(out_chan) && $stable(out_last)));

   assert_chan_step_R2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && !out_last) |=>
         (out_valid && out_chan == ($past(out_chan) + 1'b1)));

   assert_frame_start_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid) |-> (out_chan == '0));

   assert_next_frame_R4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && out_last) |=> (!out_valid || out_chan == '0));

   assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);

   assert_last_chan_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_last) |-> (out_chan == CH_W'(SLOTS - 1)));
endmodule

bind tdm_frame_rx tdm_rx_checker #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_chan  (out_chan),
   .out_last  (out_last),
   .overflow  (overflow)
);

// File: tb/test_tdm_frame_rx.sv
module test_tdm_frame_rx;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_SCK   = 3;
   localparam int SLOTS      = 16;
   localparam int SLOT_BITS  = 32;
   localparam int FBITS      = SLOTS * SLOT_BITS;
   localparam int WATCHDOG   = 190000;

   typedef struct {
      logic [31:0] data;
      logic [3:0]  chan;
      logic        last;
   } exp_t;

   logic        clk = 0;
   logic        rst = 1;
   logic        sck = 0, ws = 0, sd = 0;
   logic [15:0] idle_limit = 16'd20;
   logic        out_valid, out_ready, out_last, overflow;
   logic [31:0] out_data;
   logic [3:0]  out_chan;

   int   tests = 0, fails = 0, cycles = 0, next_fid = 0, ready_mode = 1;
   logic [15:0] lfsr = 16'hACE1;
   exp_t exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   tdm_frame_rx i_tdm_frame_rx (
      .clk(clk), .rst(rst), .sck_in(sck), .ws_in(ws), .sd_in(sd),
      .idle_limit(idle_limit), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_chan(out_chan), .out_last(out_last),
      .overflow(overflow));

   function automatic logic [31:0] word_of(int fid, int slot);
      return {8'(fid * 37 + 5), 4'(slot), 4'hC, 16'(fid * 1009 + slot * 257 + 1)};
   endfunction

   task automatic check(input logic ok, input string req, input logic [31:0] act,
                        input logic [31:0] expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic push_frame(input int fid);
      for (int s = 0; s < SLOTS; s++)
         exp_q.push_back('{data: word_of(fid, s), chan: 4'(s), last: (s == SLOTS - 1)});
   endtask

   // One bit-clock period; the rising edge carries (w, d).
   task automatic bclk(input logic w, input logic d, input int push_fid);
      sck = 0; ws = w; sd = d;
      repeat (HALF_SCK) @(posedge clk);
      #1 sck = 1;
      if (push_fid >= 0) push_frame(push_fid);
      repeat (HALF_SCK) @(posedge clk);
      #1;
   endtask

   task automatic junk(input int n, input logic first_sync);
      for (int i = 0; i < n; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         bclk(first_sync && i == 0, lfsr[0], -1);
      end
   endtask

   // Sync edge, then n frames; syncs sit on each frame's final edge except the last.
   task automatic play_frames(input int n, input logic first_only);
      bclk(1'b1, 1'b0, -1);
      for (int f = 0; f < n; f++) begin
         int fid = next_fid++;
         for (int b = 0; b < FBITS; b++) begin
            logic [31:0] w = word_of(fid, b / SLOT_BITS);
            bit fin = (b == FBITS - 1);
            bclk(fin && (f < n - 1), w[31 - (b % SLOT_BITS)],
                 (fin && (!first_only || f == 0)) ? fid : -1);
         end
      end
   endtask

   task automatic drain(input string req);
      for (int i = 0; i < 4000 && (exp_q.size() != 0 || out_valid); i++) @(posedge clk);
      repeat (4) @(posedge clk);
      check(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (ready_mode)
         0:       out_ready = 1'b0;
         1:       out_ready = 1'b1;
         default: out_ready = lfsr[3];
      endcase
   end

   // Per-clock comparison against the expected word stream.
   always @(negedge clk) begin
      cycles++;
      if (!rst && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R4 word offered with no completed frame", {28'd0, out_chan}, 0);
         end else begin
            check(out_data == exp_q[0].data, "R1/R2/R8 data", out_data, exp_q[0].data);
            check(out_chan == exp_q[0].chan, "R2 chan", {28'd0, out_chan}, {28'd0, exp_q[0].chan});
            check(out_last == exp_q[0].last, "R3 last", {31'd0, out_last}, {31'd0, exp_q[0].last});
            if (out_ready) void'(exp_q.pop_front());
         end
      end
      if (cycles > WATCHDOG) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      out_ready = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(out_valid == 0, "R10 valid in reset", {31'd0, out_valid}, 0);
      check(overflow == 0, "R10 overflow in reset", {31'd0, overflow}, 0);
      @(posedge clk) #1 rst = 0;
      @(negedge clk);
      check(out_valid == 0 && overflow == 0, "R10 after reset", {30'd0, out_valid, overflow}, 0);

      // R7 bits before any sync, then R11 frames ending without a sync
      junk(100, 1'b0);
      check(out_valid == 0, "R7 no output before sync", {31'd0, out_valid}, 0);
      play_frames(2, 1'b0);
      drain("R11 frames delivered");

      // back-to-back frames with irregular out_ready (R8)
      ready_mode = 2;
      play_frames(3, 1'b0);
      drain("R8 backpressure drain");
      ready_mode = 1;

      // R5 early sync: partial frame then a new sync
      junk(300, 1'b1);
      play_frames(2, 1'b0);
      drain("R5 early sync realign");

      // R6 stall mid-frame, stray bits without sync, then a clean frame
      junk(200, 1'b1);
      repeat (40) @(posedge clk);
      junk(400, 1'b0);
      repeat (20) @(posedge clk);
      check(out_valid == 0 && exp_q.size() == 0, "R6 nothing after stall",
            {31'd0, out_valid}, 0);
      play_frames(1, 1'b0);
      drain("R6 resync after stall");
      check(overflow == 0, "R9 no overflow yet", {31'd0, overflow}, 0);

      // R9 second frame completes while first is held
      ready_mode = 0;
      play_frames(2, 1'b1);
      repeat (10) @(posedge clk);
      @(negedge clk);
      check(overflow == 1, "R9 overflow set", {31'd0, overflow}, 1);
      check(out_valid == 1 && out_chan == 0, "R9 first frame held", {28'd0, out_chan}, 0);
      ready_mode = 1;
      drain("R9 only first frame delivered");
      check(overflow == 1, "R9 overflow sticky", {31'd0, overflow}, 1);

      @(posedge clk) #1 rst = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(overflow == 0 && out_valid == 0, "R10 reset clears", {30'd0, out_valid, overflow}, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule